// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps renamed micro-operations in program order while they execute out of order. Each one gets an entry at the tail of a circular buffer. The entry carries a sequence stamp, which is the tail pointer including its wrap bit, and the stamp is handed back to the renaming stage. Execution units report completion against the entry index. A completion carries the result value, a fault flag and a branch-mispredict flag. Consumers that are waiting for a result can read any completed, unretired entry through dedicated read ports.

Each cycle, up to three of the oldest entries are committed, strictly in stamp order. A committed entry writes its result into the architectural register file. It also tells the renaming table that its stamp has been released. A mispredicted branch commits normally and then cuts away everything younger than itself. A faulted entry never writes architectural state; instead it raises a trap carrying its stamp. An interrupt request raises a trap at the head through the same path. Both cases leave the buffer empty.

Allocation is a valid/ready stream. An entry is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_valid` may be held high across any number of stalled cycles with no side effect. Completion, interrupt, retirement and flush pins are plain strobes with no back-pressure. The retirement consumers must accept every write in the cycle it is presented.

Top module: `reorder_buffer`

## Requirements
- R1: An accepted allocation stores the destination register at the tail. `alloc_tag` shows the stamp it receives (6 bits: entry index in bits 4:0, wrap bit in bit 5). After reset the stamps start at 0 and rise by one per accepted allocation.
- R2: `alloc_ready` is low when 32 entries are held, and also in any cycle where `trap_valid` or `redirect_valid` is high. An `alloc_valid` that is not accepted changes nothing.
- R3: A completion on `cmp_idx` marks that held entry done and records its data and flags. A completion naming an index that is not currently held is ignored.
- R4: Commitment takes at most 3 entries per cycle, oldest first. Lane k carries the k-th oldest entry. The set of active lanes always starts at lane 0 with no gaps. The scan stops at the first entry that is not done.
- R5: Each committed lane drives `rf_we`, `rf_addr` (destination) and `rf_data` (result). The matching `rel_valid` lane is high with `rel_stamp` set to the entry's stamp.
- R6: A done entry flagged as mispredicted commits as the last lane of its cycle. It raises `redirect_valid` with its stamp, and every younger entry is discarded. The next allocation receives the branch stamp plus one.
- R7: A done entry flagged as faulted is not written. Older entries in the same cycle still commit. `trap_valid` rises with the faulted stamp, the buffer empties, and the next allocation reuses that stamp.
- R8: While `irq_req` is high, nothing commits. `trap_valid` rises with the head stamp and the buffer empties.
- R9: Read port p reports `rd_ok` high, together with the stored result, exactly when the entry at its index is held, done and not faulted.
- R10: After reset the buffer is empty, `alloc_ready` is high, and no write, release, trap or redirect is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Buffer can take an allocation |
| alloc_dest | input | AREG_W | Architectural destination of the new entry |
| alloc_tag | output | IDX_W+1 | Stamp given to the next allocation |
| cmp_valid | input | 1 | Completion strobe |
| cmp_idx | input | IDX_W | Entry index being completed |
| cmp_data | input | DATA_W | Result value |
| cmp_fault | input | 1 | Entry faulted |
| cmp_mispred | input | 1 | Entry is a mispredicted branch |
| irq_req | input | 1 | Interrupt request, taken at the head |
| rf_we | output | RET_W | Per-lane architectural write enable |
| rf_addr | output | RET_W*AREG_W | Per-lane architectural register |
| rf_data | output | RET_W*DATA_W | Per-lane committed value |
| rel_valid | output | RET_W | Per-lane release to the renaming table |
| rel_stamp | output | RET_W*(IDX_W+1) | Per-lane released stamp |
| trap_valid | output | 1 | Fault or interrupt taken, buffer flushed |
| trap_stamp | output | IDX_W+1 | Stamp of the trapping position |
| redirect_valid | output | 1 | Mispredicted branch committed, younger entries flushed |
| redirect_stamp | output | IDX_W+1 | Stamp of that branch |
| rd_idx | input | RD_PORTS*IDX_W | Per-port entry index to read |
| rd_ok | output | RD_PORTS | Per-port result available |
| rd_data | output | RD_PORTS*DATA_W | Per-port result value |

## Verification
The bench uses the default parameters: 32 entries, 3 commit lanes, 2 read ports, 5-bit register numbers and 32-bit data. With 32 entries and a 6-bit stamp, a few thousand cycles wrap the stamp many times. That exercises the wrap bit both in the full test and in the held-window test that filters stale completions. With three lanes, a commit group can end on a not-done entry, a fault, or a branch at any lane position. An all-allocate phase fills the buffer to the full boundary, and an interrupt-heavy phase checks traps against buffers of every occupancy.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Why the retirement scan ended a cycle with a flush, if it did.
  typedef enum logic [1:0] {
    FL_NONE   = 2'd0,
    FL_FAULT  = 2'd1,
    FL_BRANCH = 2'd2,
    FL_IRQ    = 2'd3
  } flush_e;
endpackage

// File: rtl/rob_store.sv
// Entry storage: status bits with reset, payload without.
// DEPTH must be a power of two so that indices wrap naturally.
module rob_store #(
  parameter int DEPTH    = 32,
  parameter int AREG_W   = 5,
  parameter int DATA_W   = 32,
  parameter int RET_W    = 3,
  parameter int RD_PORTS = 2,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               alloc_we,
  input  logic [IDX_W-1:0]                   alloc_idx,
  input  logic [AREG_W-1:0]                  alloc_dest,
  input  logic                               cmp_we,
  input  logic [IDX_W-1:0]                   cmp_idx,
  input  logic [DATA_W-1:0]                  cmp_data,
  input  logic                               cmp_fault,
  input  logic                               cmp_mis,
  input  logic [IDX_W-1:0]                   head_idx,
  output logic [RET_W-1:0]                   lane_done,
  output logic [RET_W-1:0]                   lane_fault,
  output logic [RET_W-1:0]                   lane_mis,
  output logic [RET_W-1:0][AREG_W-1:0]       lane_dest,
  output logic [RET_W-1:0][DATA_W-1:0]       lane_data,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]     rd_idx,
  output logic [RD_PORTS-1:0]                rd_done,
  output logic [RD_PORTS-1:0]                rd_fault,
  output logic [RD_PORTS-1:0][DATA_W-1:0]    rd_data
);
  logic [DEPTH-1:0]  done_q, fault_q, mis_q;
  logic [AREG_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  // A completion only targets held entries and allocation only the free
  // tail slot, so the two writes never hit the same index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      fault_q <= '0;
      mis_q   <= '0;
    end else begin
      if (alloc_we) begin
        done_q[alloc_idx]  <= 1'b0;
        fault_q[alloc_idx] <= 1'b0;
        mis_q[alloc_idx]   <= 1'b0;
      end
      if (cmp_we) begin
        done_q[cmp_idx]  <= 1'b1;
        fault_q[cmp_idx] <= cmp_fault;
        mis_q[cmp_idx]   <= cmp_mis;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_we) dest_q[alloc_idx] <= alloc_dest;
    if (cmp_we)   data_q[cmp_idx]   <= cmp_data;
  end

  for (genvar k = 0; k < RET_W; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign idx           = head_idx + IDX_W'(k);
    assign lane_done[k]  = done_q[idx];
    assign lane_fault[k] = fault_q[idx];
    assign lane_mis[k]   = mis_q[idx];
    assign lane_dest[k]  = dest_q[idx];
    assign lane_data[k]  = data_q[idx];
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_done[p]  = done_q[rd_idx[p]];
    assign rd_fault[p] = fault_q[rd_idx[p]];
    assign rd_data[p]  = data_q[rd_idx[p]];
  end
endmodule

// File: rtl/rob_retire_sel.sv
// Scans the oldest RET_W entries and decides what commits this cycle.
module rob_retire_sel
  import rob_pkg::*;
#(
  parameter int RET_W   = 3,
  parameter int STAMP_W = 6,
  parameter int NRET_W  = $clog2(RET_W + 1)
) (
  input  logic               irq,
  input  logic [STAMP_W-1:0] head,
  input  logic [STAMP_W-1:0] count,
  input  logic [RET_W-1:0]   lane_done,
  input  logic [RET_W-1:0]   lane_fault,
  input  logic [RET_W-1:0]   lane_mis,
  output logic [RET_W-1:0]   ret_mask,
  output logic [NRET_W-1:0]  n_ret,
  output flush_e             kind,
  output logic [STAMP_W-1:0] flush_stamp
);
  logic go;

  always_comb begin
    ret_mask    = '0;
    n_ret       = '0;
    kind        = FL_NONE;
    flush_stamp = head;
    go          = 1'b1;
    for (int k = 0; k < RET_W; k++) begin
      if (go) begin
        if (STAMP_W'(k) >= count || !lane_done[k]) begin
          go = 1'b0;
        end else if (lane_fault[k]) begin
          kind        = FL_FAULT;
          flush_stamp = head + STAMP_W'(k);
          go          = 1'b0;
        end else begin
          ret_mask[k] = 1'b1;
          n_ret       = n_ret + 1'b1;
          if (lane_mis[k]) begin
            kind        = FL_BRANCH;
            flush_stamp = head + STAMP_W'(k);
            go          = 1'b0;
          end
        end
      end
    end
    if (irq) begin
      ret_mask    = '0;
      n_ret       = '0;
      kind        = FL_IRQ;
      flush_stamp = head;
    end
  end
endmodule

// File: rtl/rob_ptr_ctrl.sv
// Head and tail stamps; the extra wrap bit separates full from empty.
module rob_ptr_ctrl #(
  parameter int DEPTH   = 32,
  parameter int STAMP_W = 6,
  parameter int NRET_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_fire,
  input  logic [NRET_W-1:0]  n_ret,
  input  logic               flush,
  input  logic [STAMP_W-1:0] flush_base,
  output logic [STAMP_W-1:0] head,
  output logic [STAMP_W-1:0] tail,
  output logic [STAMP_W-1:0] count,
  output logic               full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (flush) begin
      head <= flush_base;
      tail <= flush_base;
    end else begin
      head <= head + STAMP_W'(n_ret);
      tail <= tail + STAMP_W'(alloc_fire);
    end
  end

  assign count = tail - head;
  assign full  = (count == STAMP_W'(DEPTH));
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import rob_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int AREG_W   = 5,
  parameter int DATA_W   = 32,
  parameter int RET_W    = 3,
  parameter int RD_PORTS = 2,
  parameter int IDX_W    = $clog2(DEPTH),
  parameter int STAMP_W  = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  output logic                         alloc_ready,
  input  logic [AREG_W-1:0]            alloc_dest,
  output logic [STAMP_W-1:0]           alloc_tag,
  input  logic                         cmp_valid,
  input  logic [IDX_W-1:0]             cmp_idx,
  input  logic [DATA_W-1:0]            cmp_data,
  input  logic                         cmp_fault,
  input  logic                         cmp_mispred,
  input  logic                         irq_req,
  output logic [RET_W-1:0]             rf_we,
  output logic [RET_W*AREG_W-1:0]      rf_addr,
  output logic [RET_W*DATA_W-1:0]      rf_data,
  output logic [RET_W-1:0]             rel_valid,
  output logic [RET_W*STAMP_W-1:0]     rel_stamp,
  output logic                         trap_valid,
  output logic [STAMP_W-1:0]           trap_stamp,
  output logic                         redirect_valid,
  output logic [STAMP_W-1:0]           redirect_stamp,
  input  logic [RD_PORTS*IDX_W-1:0]    rd_idx,
  output logic [RD_PORTS-1:0]          rd_ok,
  output logic [RD_PORTS*DATA_W-1:0]   rd_data
);
  localparam int NRET_W = $clog2(RET_W + 1);

  logic [STAMP_W-1:0] head, tail, count, flush_stamp, flush_base;
  logic               full, alloc_fire, cmp_live, flush;
  logic [RET_W-1:0]   lane_done, lane_fault, lane_mis, ret_mask;
  logic [RET_W-1:0][AREG_W-1:0] lane_dest;
  logic [RET_W-1:0][DATA_W-1:0] lane_data;
  logic [NRET_W-1:0]  n_ret;
  flush_e             kind;
  logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx_a;
  logic [RD_PORTS-1:0]             rd_done, rd_fault, rd_live;
  logic [RD_PORTS-1:0][DATA_W-1:0] rd_val;

  // An index is held when its distance from the head is below the count.
  function automatic logic is_held(input logic [IDX_W-1:0] idx,
                                   input logic [STAMP_W-1:0] hd,
                                   input logic [STAMP_W-1:0] cnt);
    logic [IDX_W-1:0] off;
    off = idx - hd[IDX_W-1:0];
    return {1'b0, off} < cnt;
  endfunction

  assign cmp_live    = cmp_valid && is_held(cmp_idx, head, count);
  assign flush       = (kind != FL_NONE);
  assign alloc_ready = !full && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  // A trap restarts at the trapping stamp; a branch keeps itself.
  assign flush_base  = (kind == FL_BRANCH) ? flush_stamp + 1'b1 : flush_stamp;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .STAMP_W(STAMP_W), .NRET_W(NRET_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .n_ret      (n_ret),
    .flush      (flush),
    .flush_base (flush_base),
    .head       (head),
    .tail       (tail),
    .count      (count),
    .full       (full)
  );

  rob_store #(
    .DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W),
    .RET_W(RET_W), .RD_PORTS(RD_PORTS), .IDX_W(IDX_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_we   (alloc_fire),
    .alloc_idx  (tail[IDX_W-1:0]),
    .alloc_dest (alloc_dest),
    .cmp_we     (cmp_live),
    .cmp_idx    (cmp_idx),
    .cmp_data   (cmp_data),
    .cmp_fault  (cmp_fault),
    .cmp_mis    (cmp_mispred),
    .head_idx   (head[IDX_W-1:0]),
    .lane_done  (lane_done),
    .lane_fault (lane_fault),
    .lane_mis   (lane_mis),
    .lane_dest  (lane_dest),
    .lane_data  (lane_data),
    .rd_idx     (rd_idx_a),
    .rd_done    (rd_done),
    .rd_fault   (rd_fault),
    .rd_data    (rd_val)
  );

  rob_retire_sel #(.RET_W(RET_W), .STAMP_W(STAMP_W), .NRET_W(NRET_W)) u_sel (
    .irq         (irq_req),
    .head        (head),
    .count       (count),
    .lane_done   (lane_done),
    .lane_fault  (lane_fault),
    .lane_mis    (lane_mis),
    .ret_mask    (ret_mask),
    .n_ret       (n_ret),
    .kind        (kind),
    .flush_stamp (flush_stamp)
  );

  assign rf_we          = ret_mask;
  assign rel_valid      = ret_mask;
  assign trap_valid     = (kind == FL_FAULT) || (kind == FL_IRQ);
  assign trap_stamp     = flush_stamp;
  assign redirect_valid = (kind == FL_BRANCH);
  assign redirect_stamp = flush_stamp;

  for (genvar k = 0; k < RET_W; k++) begin : g_out
    assign rf_addr[k*AREG_W +: AREG_W]     = lane_dest[k];
    assign rf_data[k*DATA_W +: DATA_W]     = lane_data[k];
    assign rel_stamp[k*STAMP_W +: STAMP_W] = head + STAMP_W'(k);
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_byp
    assign rd_idx_a[p]                 = rd_idx[p*IDX_W +: IDX_W];
    assign rd_live[p]                  = is_held(rd_idx_a[p], head, count);
    assign rd_ok[p]                    = rd_live[p] && rd_done[p] && !rd_fault[p];
    assign rd_data[p*DATA_W +: DATA_W] = rd_val[p];
  end
endmodule

// File: rtl/reorder_buffer_checker.sv
module reorder_buffer_checker #(
  parameter int RET_W   = 3,
  parameter int STAMP_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_valid,
  input logic               alloc_ready,
  input logic [STAMP_W-1:0] alloc_tag,
  input logic               irq_req,
  input logic [RET_W-1:0]   rf_we,
  input logic               trap_valid,
  input logic [STAMP_W-1:0] trap_stamp,
  input logic               redirect_valid,
  input logic [STAMP_W-1:0] redirect_stamp
);
  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_tag == STAMP_W'($past(alloc_tag) + 1'b1)); // R1

  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid || redirect_valid) |-> !alloc_ready); // R2

  AST_LANES_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we & RET_W'(rf_we + 1'b1)) == '0); // R4

  AST_BRANCH_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> alloc_tag == STAMP_W'($past(redirect_stamp) + 1'b1)); // R6

  AST_TRAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> alloc_tag == $past(trap_stamp)); // R7

  AST_IRQ_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (rf_we == '0 && trap_valid && !redirect_valid)); // R8
endmodule

bind reorder_buffer reorder_buffer_checker #(.RET_W(RET_W), .STAMP_W(STAMP_W)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .alloc_valid    (alloc_valid),
  .alloc_ready    (alloc_ready),
  .alloc_tag      (alloc_tag),
  .irq_req        (irq_req),
  .rf_we          (rf_we),
  .trap_valid     (trap_valid),
  .trap_stamp     (trap_stamp),
  .redirect_valid (redirect_valid),
  .redirect_stamp (redirect_stamp)
);

// File: tb/reorder_buffer_bench.sv
`timescale 1ns/1ps
module reorder_buffer_bench;
  localparam int DEPTH = 32, AREG_W = 5, DATA_W = 32, RET_W = 3, RD_PORTS = 2;
  localparam int IDX_W = 5, STAMP_W = 6, SMOD = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                       alloc_valid = 1'b0, alloc_ready;
  logic [AREG_W-1:0]          alloc_dest = '0;
  logic [STAMP_W-1:0]         alloc_tag;
  logic                       cmp_valid = 1'b0, cmp_fault = 1'b0, cmp_mispred = 1'b0;
  logic [IDX_W-1:0]           cmp_idx = '0;
  logic [DATA_W-1:0]          cmp_data = '0;
  logic                       irq_req = 1'b0;
  logic [RET_W-1:0]           rf_we, rel_valid;
  logic [RET_W*AREG_W-1:0]    rf_addr;
  logic [RET_W*DATA_W-1:0]    rf_data;
  logic [RET_W*STAMP_W-1:0]   rel_stamp;
  logic                       trap_valid, redirect_valid;
  logic [STAMP_W-1:0]         trap_stamp, redirect_stamp;
  logic [RD_PORTS*IDX_W-1:0]  rd_idx = '0;
  logic [RD_PORTS-1:0]        rd_ok;
  logic [RD_PORTS*DATA_W-1:0] rd_data;

  reorder_buffer u_reorder_buffer (.*);

  int n_checks = 0, n_fail = 0;
  logic [AREG_W-1:0] m_dest [DEPTH];
  logic [DATA_W-1:0] m_data [DEPTH];
  bit m_done [DEPTH];
  bit m_fault [DEPTH];
  bit m_mis [DEPTH];
  int m_head = 0, m_tail = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit held(input int idx);
    int off = (idx - (m_head % DEPTH) + DEPTH) % DEPTH;
    return off < (m_tail - m_head);
  endfunction

  // One cycle: drive at the falling edge, compare, then advance the model.
  task automatic cycle(input int p_alloc, input int p_cmp, input int p_stale,
                       input int p_irq_pm, input int p_fault, input int p_mis);
    int cnt, n, ridx;
    bit etrap, eredir, eready, cmp_hit;
    logic [RET_W-1:0] ewe;
    logic [STAMP_W-1:0] estamp, erstamp;
    @(negedge clk);
    cnt = m_tail - m_head;
    alloc_valid = ($urandom % 100) < p_alloc;
    alloc_dest  = AREG_W'($urandom);
    irq_req     = ($urandom % 1000) < p_irq_pm;
    cmp_valid = 1'b0; cmp_hit = 1'b0;
    cmp_data = $urandom;
    cmp_fault = ($urandom % 100) < p_fault;
    cmp_mispred = ($urandom % 100) < p_mis;
    if (cnt > 0 && ($urandom % 100) < p_cmp) begin
      int e = (m_head + int'($urandom % cnt)) % DEPTH;
      if (!m_done[e]) begin
        cmp_valid = 1'b1; cmp_idx = IDX_W'(e); cmp_hit = 1'b1;
      end
    end else if (cnt < DEPTH && ($urandom % 100) < p_stale) begin
      // R3: an index outside the held window must be ignored
      cmp_valid = 1'b1;
      cmp_idx = IDX_W'((m_head + cnt + int'($urandom % (DEPTH - cnt))) % DEPTH);
    end
    rd_idx = (RD_PORTS*IDX_W)'($urandom);
    #1;
    ewe = '0; n = 0; etrap = 0; eredir = 0;
    estamp = STAMP_W'(m_head % SMOD); erstamp = '0;
    if (irq_req) etrap = 1;
    else for (int k = 0; k < RET_W; k++) begin
      int e = (m_head + k) % DEPTH;
      if (k >= cnt || !m_done[e]) break;
      if (m_fault[e]) begin etrap = 1; estamp = STAMP_W'((m_head + k) % SMOD); break; end
      ewe[k] = 1'b1; n++;
      chk("R5", "rf_addr", 64'(rf_addr[k*AREG_W +: AREG_W]), 64'(m_dest[e]));
      chk("R5", "rf_data", 64'(rf_data[k*DATA_W +: DATA_W]), 64'(m_data[e]));
      chk("R4", "rel_stamp", 64'(rel_stamp[k*STAMP_W +: STAMP_W]), 64'((m_head + k) % SMOD));
      if (m_mis[e]) begin eredir = 1; erstamp = STAMP_W'((m_head + k) % SMOD); break; end
    end
    eready = (cnt < DEPTH) && !etrap && !eredir;
    chk("R4", "rf_we", 64'(rf_we), 64'(ewe));
    chk("R5", "rel_valid", 64'(rel_valid), 64'(ewe));
    chk(irq_req ? "R8" : "R7", "trap_valid", 64'(trap_valid), 64'(etrap));
    if (etrap) chk(irq_req ? "R8" : "R7", "trap_stamp", 64'(trap_stamp), 64'(estamp));
    chk("R6", "redirect_valid", 64'(redirect_valid), 64'(eredir));
    if (eredir) chk("R6", "redirect_stamp", 64'(redirect_stamp), 64'(erstamp));
    chk("R2", "alloc_ready", 64'(alloc_ready), 64'(eready));
    chk("R1", "alloc_tag", 64'(alloc_tag), 64'(m_tail % SMOD));
    for (int p = 0; p < RD_PORTS; p++) begin
      bit eok;
      ridx = int'(rd_idx[p*IDX_W +: IDX_W]);
      eok = held(ridx) && m_done[ridx] && !m_fault[ridx];
      chk("R9", "rd_ok", 64'(rd_ok[p]), 64'(eok));
      if (eok) chk("R9", "rd_data", 64'(rd_data[p*DATA_W +: DATA_W]), 64'(m_data[ridx]));
    end
    // model update for the coming rising edge
    if (cmp_hit) begin
      int e = int'(cmp_idx);
      m_done[e] = 1; m_data[e] = cmp_data; m_fault[e] = cmp_fault; m_mis[e] = cmp_mispred;
    end
    m_head += n;
    if (etrap || eredir) m_tail = m_head;
    else if (alloc_valid && eready) begin
      int e = m_tail % DEPTH;
      m_dest[e] = alloc_dest; m_done[e] = 0; m_fault[e] = 0; m_mis[e] = 0;
      m_tail++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10: empty after reset
    chk("R10", "alloc_ready", 64'(alloc_ready), 64'd1);
    chk("R10", "alloc_tag", 64'(alloc_tag), 64'd0);
    chk("R10", "rf_we", 64'(rf_we), 64'd0);
    chk("R10", "rel_valid", 64'(rel_valid), 64'd0);
    chk("R10", "trap_valid", 64'(trap_valid), 64'd0);
    chk("R10", "redirect_valid", 64'(redirect_valid), 64'd0);
    repeat (40) cycle(100, 0, 30, 0, 0, 0);      // fill to the full boundary (R2)
    repeat (80) cycle(0, 60, 20, 0, 0, 0);       // out-of-order drain (R3, R4)
    repeat (3000) cycle(70, 80, 10, 0, 2, 4);    // mixed traffic (R5, R6, R7)
    repeat (2000) cycle(90, 95, 5, 0, 0, 2);     // multi-lane commit bursts
    repeat (2000) cycle(70, 70, 10, 25, 3, 5);   // interrupt-heavy (R8)
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule